// File: doc/BRIEF.md
# Serial Mode Control Register Port

This block is a four-wire serial slave that gives a host access to a small bank of 8-bit configuration registers. Every transaction is 16 serial clock periods long. The first bit says whether the host reads or writes. Seven address bits follow, most significant first, and then eight data bits, most significant first. The register contents appear in parallel on `cfg_regs`. The register that controls the output driver is also split into named fields, so that neighbouring logic can use them directly.

The slave runs entirely in the system clock domain. Chip select, serial clock and serial data in pass through a synchronizer before use. The block then finds rising serial clock edges by comparing consecutive synchronized samples. For this to work, each serial clock level must be held for at least four system clock periods. Under that rule, the data output has settled before the host's next rising edge.

The serial data out is a three-state pin, modelled as a data bit `spi_miso` and an enable `spi_miso_oe`. It is enabled only during the data half of a read.

Top module: `spi_mcr_port`

## Requirements
- R1: After reset every register holds 00h, `cfg_regs` and the field outputs are all zero, and `spi_miso_oe` is low.
- R2: While `spi_cs_n` is low, one bit of `spi_mosi` is captured on each rising edge of `spi_sclk`. The bits arrive in this order: the direction flag (1 = read, 0 = write), address bits 6 down to 0, then data bits 7 down to 0.
- R3: A write loads the addressed register when the 16th rising edge is captured. Register i appears on `cfg_regs[8i+7:8i]`, and no other register changes.
- R4: During a read, after the k-th rising edge (k = 8 to 15) `spi_miso_oe` is high and `spi_miso` carries bit 15-k of the addressed register.
- R5: `spi_miso_oe` is low in four cases: while `spi_cs_n` is high, before the 8th edge of a read, after the 16th edge of a read, and throughout a write.
- R6: If `spi_cs_n` rises before the 16th edge, no register changes.
- R7: Rising edges after the 16th are ignored until `spi_cs_n` returns high. They cause no second write and do not shift the readback.
- R8: Addresses at or above NUM_REGS (default 5) read as 00h, and writes to them change nothing.
- R9: Register 02h drives four field outputs: bits 7..5 give `drv_strength`, bit 4 gives `term_en`, bit 3 gives `out_disable` and bits 2..0 give `lane_mode`.
- R10: The drive-strength code 011, which has no defined setting, is still stored, output and read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, valid when enabled |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| cfg_regs | output | NUM_REGS*8 | All registers, register i in bits 8i+7..8i |
| drv_strength | output | 3 | Output driver current code |
| term_en | output | 1 | Output termination enable |
| out_disable | output | 1 | Output stage off |
| lane_mode | output | 3 | Output lane and serialization mode |

## Verification
The hardest cases to reach are those where the host breaks the 16-edge rhythm. One is a frame cut short just before its final edge. Another is a frame that keeps clocking after the 16th edge, with trailing bits that would overwrite the register if they were still shifted. The bench drives both through a single transfer task that takes an arbitrary bit vector and edge count. The task samples the output enable before every rising edge and once after the last, so the exact edges at which the pad turns on and off are checked as well as the data.

// File: rtl/spi_mcr_pkg.sv
package spi_mcr_pkg;
  // Field layout of the output-driver register
  localparam int DRV_LSB  = 5;
  localparam int DRV_W    = 3;
  localparam int TERM_BIT = 4;
  localparam int OFF_BIT  = 3;
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 3;
  // Synchronized serial inputs bundle
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic mosi;
  } spi_in_t;
endpackage

// File: rtl/spi_mcr_sync.sv
module spi_mcr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mcr_frame.sv
module spi_mcr_frame #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output logic              miso_oe
);
  localparam int FRAME = 1 + ADDR_W + DATA_W;
  localparam int HDR   = 1 + ADDR_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam int BI_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] C_HDR   = CNT_W'(HDR);
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HDR-1:0]    hdr_q, hdr_d;
  logic [DATA_W-2:0] dat_q, dat_d;
  logic              rise, active, rd_phase;
  logic [BI_W-1:0]   bit_pos;

  assign active = ~cs_n_s;
  assign rise   = sclk_s & ~sclk_q;

  // Next-state logic
  always_comb begin
    cnt_d = cnt_q;
    hdr_d = hdr_q;
    dat_d = dat_q;
    wr_en = 1'b0;
    if (!active) begin
      cnt_d = '0;
    end else if (rise && (cnt_q < C_FRAME)) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q < C_HDR)       hdr_d = {hdr_q[HDR-2:0], mosi_s};
      else if (cnt_q < C_LAST) dat_d = {dat_q[DATA_W-3:0], mosi_s};
      if ((cnt_q == C_LAST) && !hdr_q[HDR-1]) wr_en = 1'b1;
    end
  end

  assign addr    = hdr_q[ADDR_W-1:0];
  assign wr_data = {dat_q, mosi_s};

  // Readback: data bits follow the header, MSB first
  assign rd_phase = active && hdr_q[HDR-1] && (cnt_q >= C_HDR) && (cnt_q < C_FRAME);
  assign bit_pos  = BI_W'(C_LAST - cnt_q);
  assign miso_oe  = rd_phase;
  assign miso     = rd_phase & rd_data[bit_pos];

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt_q  <= '0;
      hdr_q  <= '0;
      dat_q  <= '0;
    end else begin
      sclk_q <= sclk_s;
      cnt_q  <= cnt_d;
      hdr_q  <= hdr_d;
      dat_q  <= dat_d;
    end
  end
endmodule

// File: rtl/spi_mcr_bank.sv
module spi_mcr_bank #(
  parameter int NUM_REGS = 5,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q, d;
    logic              hit;

    assign hit = wr_en && (addr == ADDR_W'(i));

    always_comb begin
      d = q;
      if (hit) d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign regs_flat[i*DATA_W +: DATA_W] = q;
  end

  // Read mux; unmatched addresses return zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) rd_data = regs_flat[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/spi_mcr_port.sv
module spi_mcr_port
  import spi_mcr_pkg::*;
#(
  parameter int NUM_REGS    = 5,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OUT_REG     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_cs_n,
  input  logic                       spi_sclk,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  output logic                       spi_miso_oe,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs,
  output logic [DRV_W-1:0]           drv_strength,
  output logic                       term_en,
  output logic                       out_disable,
  output logic [MODE_W-1:0]          lane_mode
);
  localparam int OUT_BASE = OUT_REG * DATA_W;

  // Asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  spi_in_t             raw_in, syn_in;
  logic                cs_n_s, sclk_s, mosi_s;
  logic                wr_en;
  logic [ADDR_W-1:0]   wr_addr;
  logic [DATA_W-1:0]   wr_data, rd_data;
  logic [DATA_W-1:0]   out_reg;

  assign raw_in = '{cs_n: spi_cs_n, sclk: spi_sclk, mosi: spi_mosi};

  spi_mcr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d(raw_in), .q(syn_in)
  );

  assign cs_n_s = syn_in.cs_n;
  assign sclk_s = syn_in.sclk;
  assign mosi_s = syn_in.mosi;

  spi_mcr_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_core_n),
    .cs_n_s(cs_n_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
    .rd_data(rd_data),
    .wr_en(wr_en), .addr(wr_addr), .wr_data(wr_data),
    .miso(spi_miso), .miso_oe(spi_miso_oe)
  );

  spi_mcr_bank #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_core_n),
    .wr_en(wr_en), .addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .regs_flat(cfg_regs)
  );

  // Field decode of the output-driver register
  assign out_reg      = cfg_regs[OUT_BASE +: DATA_W];
  assign drv_strength = out_reg[DRV_LSB +: DRV_W];
  assign term_en      = out_reg[TERM_BIT];
  assign out_disable  = out_reg[OFF_BIT];
  assign lane_mode    = out_reg[MODE_LSB +: MODE_W];
endmodule

// File: rtl/spi_mcr_port_chk.sv
module spi_mcr_port_chk #(
  parameter int NUM_REGS = 5,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n_s,
  input logic                       spi_miso_oe,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [DATA_W-1:0]          rd_data,
  input logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
  // R3: registers move only on a write strobe
  a_r3_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_regs) |-> $past(wr_en));

  // R5: pad never driven while chip select is inactive
  a_r5_oe_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !spi_miso_oe);

  // R6: a write strobe only inside an active frame
  a_r6_strobe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cs_n_s);

  // R7: at most one strobe, never on consecutive cycles
  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R8: unimplemented addresses read zero and ignore writes
  a_r8_unimpl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr >= ADDR_W'(NUM_REGS)) |-> (rd_data == '0));

  a_r8_unimpl_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr >= ADDR_W'(NUM_REGS))) |=> $stable(cfg_regs));
endmodule

bind spi_mcr_port spi_mcr_port_chk #(
  .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .spi_miso_oe(spi_miso_oe),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_data(rd_data), .cfg_regs(cfg_regs)
);

// File: tb/spi_mcr_port_test.sv
module spi_mcr_port_test;
  localparam int NR   = 5;
  localparam int HALF = 8;

  logic clk, rst_n, cs_n, sclk, mosi;
  logic miso, miso_oe;
  logic [NR*8-1:0] cfg;
  logic [2:0] drv, lmode;
  logic term, off;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NR];

  spi_mcr_port uut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .cfg_regs(cfg),
    .drv_strength(drv), .term_en(term), .out_disable(off), .lane_mode(lmode)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Generic transfer: nbits edges, bits taken MSB-first from the low nbits of 'bits'
  task automatic xfer(input logic [31:0] bits, input int nbits, input bit is_rd,
                      output logic [7:0] rd, output int oe_bad);
    bit exp_oe;
    rd = '0;
    oe_bad = 0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = bits[nbits-1-i];
      wait_clk(HALF);
      exp_oe = is_rd && (i >= 8) && (i < 16);
      if (miso_oe !== exp_oe) oe_bad++;
      if (is_rd && i >= 8 && i < 16) rd[15-i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    exp_oe = is_rd && (nbits >= 8) && (nbits < 16);
    if (miso_oe !== exp_oe) oe_bad++;
    cs_n = 1'b1;
    wait_clk(HALF);
    if (miso_oe !== 1'b0) oe_bad++;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] r; int bad;
    xfer({16'h0, 1'b0, a, d}, 16, 1'b0, r, bad);
    chk(bad == 0, "R5 oe during write", 40'(bad), 40'h0);
    if (a < NR) model[a] = d;
  endtask

  task automatic rd_chk(input logic [6:0] a, input string tag);
    logic [7:0] r, e; int bad;
    xfer({16'h0, 1'b1, a, 8'h00}, 16, 1'b1, r, bad);
    e = (a < NR) ? model[a] : 8'h00;
    chk(r == e, tag, 40'(r), 40'(e));
    chk(bad == 0, "R4 R5 read enable window", 40'(bad), 40'h0);
  endtask

  function automatic logic [NR*8-1:0] model_flat();
    logic [NR*8-1:0] f;
    for (int i = 0; i < NR; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic t_reset();
    chk(cfg == '0, "R1 cfg_regs after reset", 40'(cfg), 40'h0);
    chk({drv, term, off, lmode} == 8'h00, "R1 fields after reset", 40'({drv, term, off, lmode}), 40'h0);
    chk(miso_oe == 1'b0, "R1 oe after reset", 40'(miso_oe), 40'h0);
    rd_chk(7'd0, "R1 read reg0 after reset");
  endtask

  task automatic t_write_read_all();
    for (int a = 0; a < NR; a++) wr(7'(a), 8'(8'hA5 ^ (a * 37)));
    chk(cfg == model_flat(), "R3 cfg_regs after writes", 40'(cfg), 40'(model_flat()));
    for (int a = NR - 1; a >= 0; a--) rd_chk(7'(a), "R4 readback");
  endtask

  task automatic t_bit_order();
    wr(7'd1, 8'h01);
    chk(cfg[15:8] == 8'h01, "R2 data MSB first", 40'(cfg[15:8]), 40'h01);
    wr(7'd4, 8'h80);
    chk(cfg[39:32] == 8'h80, "R2 address MSB first", 40'(cfg[39:32]), 40'h80);
    chk(cfg == model_flat(), "R3 only addressed reg", 40'(cfg), 40'(model_flat()));
  endtask

  task automatic t_fields();
    wr(7'd2, 8'b101_1_0_110);
    chk(drv == 3'd5 && term && !off && lmode == 3'd6, "R9 field decode A",
        40'({drv, term, off, lmode}), 40'hB6);
    wr(7'd2, 8'b011_0_1_001);
    chk({drv, term, off, lmode} == 8'h69, "R10 unused drive code stored",
        40'({drv, term, off, lmode}), 40'h69);
    rd_chk(7'd2, "R10 unused drive code readback");
  endtask

  task automatic t_abort();
    logic [7:0] r; int bad;
    xfer({16'h0, 1'b0, 7'd1, 8'h5A} >> 4, 12, 1'b0, r, bad);
    chk(cfg == model_flat(), "R6 abort after 12 edges", 40'(cfg), 40'(model_flat()));
    xfer({16'h0, 1'b0, 7'd1, 8'h5A} >> 1, 15, 1'b0, r, bad);
    chk(cfg == model_flat(), "R6 abort after 15 edges", 40'(cfg), 40'(model_flat()));
    rd_chk(7'd1, "R6 readback after aborts");
  endtask

  task automatic t_extra_edges();
    logic [7:0] r; int bad;
    xfer({8'h0, 1'b0, 7'd3, 8'h3C, 8'hFF}, 24, 1'b0, r, bad);
    model[3] = 8'h3C;
    chk(cfg == model_flat(), "R7 extra edges after write", 40'(cfg), 40'(model_flat()));
    chk(bad == 0, "R7 oe with extra edges on write", 40'(bad), 40'h0);
    xfer({8'h0, 1'b1, 7'd3, 8'h00, 8'hFF}, 24, 1'b1, r, bad);
    chk(r == 8'h3C, "R7 read with extra edges", 40'(r), 40'h3C);
    chk(bad == 0, "R7 oe off after 16th edge", 40'(bad), 40'h0);
    chk(cfg == model_flat(), "R7 no change after long read", 40'(cfg), 40'(model_flat()));
  endtask

  task automatic t_unimpl();
    wr(7'd5, 8'hEE);
    wr(7'h7F, 8'h77);
    chk(cfg == model_flat(), "R8 writes to unimplemented ignored", 40'(cfg), 40'(model_flat()));
    rd_chk(7'd5, "R8 read address 05h");
    rd_chk(7'h7F, "R8 read address 7Fh");
  endtask

  initial begin
    cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write_read_all();
    t_bit_order();
    t_fields();
    t_abort();
    t_extra_edges();
    t_unimpl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule